// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block turns two request words into one interrupt level and decides whether that level may interrupt the running code. One word carries software-posted requests and the other carries external interrupt lines. Each word is scanned only over its own bit range. The highest active software bit yields a level counted from the bottom of the software range. The highest active external bit yields a level equal to its own position. An active external level always overrides a software level. The winning level is compared with the current priority level. A trap is requested only when the winner is nonzero and strictly higher.

Evaluation is armed out of reset. An evaluation happens when the strobe arrives while the block is armed, and it disarms the block. A handler-return event arms it again. When a trap is taken, the block loads two status registers: a summary of every in-range active request, and the winning level. These registers hold their value until the next trap. An asynchronous-trap request has no supported meaning, so a nonzero request seen during an evaluation raises an error pulse.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, trap_req, ast_err, isr_sum and intid are all zero, and the block is armed, so the first strobe is evaluated.
- R2: Software requests are taken from sw_req bit positions 4 to 18. The highest active position p in that range gives level p-3, so the levels run from 1 to 15.
- R3: External requests are taken from ext_req bit positions 20 to 30. The highest active position p in that range gives level p. Any active external request overrides every software request.
- R4: isr_sum receives each active in-range request bit at its own position: sw_req bits 4..18 and ext_req bits 20..30. All other bits of either word have no effect on the level or the summary.
- R5: A trap is raised only when the computed level is nonzero and strictly greater than the 5-bit cur_lvl input.
- R6: trap_req is a one-cycle pulse on the clock edge that samples an armed strobe. isr_sum and intid are loaded on that same edge only when the trap fires, and they hold at all other times.
- R7: An evaluation disarms the block, and later strobes are ignored until handler_ret is seen. If handler_ret arrives in the same cycle as an evaluated strobe, the block stays armed.
- R8: If ast_req is nonzero during an evaluation, ast_err pulses for one cycle on that edge, whether or not a trap fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eval_strobe | input | 1 | Request an evaluation |
| handler_ret | input | 1 | Return-from-handler event; re-arms evaluation |
| sw_req | input | SUM_W | Software request word |
| ext_req | input | SUM_W | External request word |
| ast_req | input | AST_W | Asynchronous-trap request (unsupported) |
| cur_lvl | input | LVL_W | Current priority level |
| trap_req | output | 1 | One-cycle trap request |
| isr_sum | output | SUM_W | Summary of active requests at the last trap |
| intid | output | LVL_W | Winning level at the last trap |
| ast_err | output | 1 | Error pulse for an asynchronous-trap request |

## Verification
The assertions check, on every cycle, the properties that do not depend on any particular input pattern. A trap carries a nonzero level above the priority level sampled one cycle earlier. The status registers move only with a trap. Two traps never follow each other unless a handler return came between them. An error pulse always traces back to a nonzero asynchronous request. What the assertions cannot show is the correctness of each level value: how positions map to levels, that external requests override software ones, that out-of-range bits are ignored, and how the summary is built. The bench sweeps single bits, cross pairs and pseudo-random words against every priority level and compares each result with levels it computes arithmetically.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int unsigned LVL_W_DEF = 5;

   // true when value v can be represented in w unsigned bits
   function automatic bit fits_in(input int unsigned v, input int unsigned w);
      return (w >= 32) || (v < (32'd1 << w));
   endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   if (N < 1) begin : g_bad_n
      $error("irq_prio_enc: N must be at least 1");
   end

   // highest set bit wins: later iterations overwrite earlier ones
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_lvl_select.sv
module irq_lvl_select #(
   parameter int unsigned SUM_W   = 32,
   parameter int unsigned SW_LO   = 4,
   parameter int unsigned SW_CNT  = 15,
   parameter int unsigned EXT_LO  = 20,
   parameter int unsigned EXT_CNT = 11,
   parameter int unsigned LVL_W   = 5
) (
   input  logic [SUM_W-1:0] sw_req,
   input  logic [SUM_W-1:0] ext_req,
   output logic [LVL_W-1:0] lvl,
   output logic [SUM_W-1:0] summary
);
   localparam logic [SUM_W-1:0] ONES    = '1;
   localparam logic [SUM_W-1:0] SW_MASK = (ONES >> (SUM_W - SW_CNT)) << SW_LO;
   localparam logic [SUM_W-1:0] EXT_MASK =
      (EXT_CNT == 0) ? '0 : ((ONES >> (SUM_W - EXT_CNT)) << EXT_LO);
   localparam int unsigned SIDX_W = (SW_CNT > 1) ? $clog2(SW_CNT) : 1;

   logic              sw_any;
   logic [SIDX_W-1:0] sw_idx;
   logic [LVL_W-1:0]  sw_lvl;
   logic              ext_any;
   logic [LVL_W-1:0]  ext_lvl;

   irq_prio_enc #(.N(SW_CNT), .IDX_W(SIDX_W)) u_sw_enc (
      .req (sw_req[SW_LO +: SW_CNT]),
      .any (sw_any),
      .idx (sw_idx)
   );

   // software level counts from one at the bottom of its range
   assign sw_lvl = sw_any ? LVL_W'(32'(sw_idx) + 32'd1) : '0;

   if (EXT_CNT == 0) begin : g_no_ext
      assign ext_any = 1'b0;
      assign ext_lvl = '0;
   end else begin : g_ext
      localparam int unsigned EIDX_W = (EXT_CNT > 1) ? $clog2(EXT_CNT) : 1;
      logic [EIDX_W-1:0] ext_idx;
      irq_prio_enc #(.N(EXT_CNT), .IDX_W(EIDX_W)) u_ext_enc (
         .req (ext_req[EXT_LO +: EXT_CNT]),
         .any (ext_any),
         .idx (ext_idx)
      );
      // external level is the absolute bit position
      assign ext_lvl = LVL_W'(32'(ext_idx) + EXT_LO);
   end

   assign lvl     = ext_any ? ext_lvl : sw_lvl;
   assign summary = (sw_req & SW_MASK) | (ext_req & EXT_MASK);
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned SUM_W   = 32,
   parameter int unsigned SW_LO   = 4,
   parameter int unsigned SW_CNT  = 15,
   parameter int unsigned EXT_LO  = 20,
   parameter int unsigned EXT_CNT = 11,
   parameter int unsigned LVL_W   = LVL_W_DEF,
   parameter int unsigned AST_W   = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             eval_strobe,
   input  logic             handler_ret,
   input  logic [SUM_W-1:0] sw_req,
   input  logic [SUM_W-1:0] ext_req,
   input  logic [AST_W-1:0] ast_req,
   input  logic [LVL_W-1:0] cur_lvl,
   output logic             trap_req,
   output logic [SUM_W-1:0] isr_sum,
   output logic [LVL_W-1:0] intid,
   output logic             ast_err
);
   localparam int unsigned EXT_TOP = EXT_LO + EXT_CNT;

   if (SW_CNT < 1) begin : g_bad_sw
      $error("irq_level_arbiter: software range is empty");
   end
   if (SW_LO + SW_CNT > EXT_LO) begin : g_bad_order
      $error("irq_level_arbiter: software range must sit below external range");
   end
   if (EXT_TOP > SUM_W) begin : g_bad_width
      $error("irq_level_arbiter: external range exceeds summary width");
   end
   if (!fits_in(SW_CNT, LVL_W) || !fits_in(EXT_TOP - 1, LVL_W)) begin : g_bad_lvl
      $error("irq_level_arbiter: LVL_W too narrow for the levels");
   end

   logic [LVL_W-1:0] lvl_c;
   logic [SUM_W-1:0] sum_c;
   logic             armed_q;
   logic             do_eval;
   logic             fire;

   irq_lvl_select #(
      .SUM_W(SUM_W), .SW_LO(SW_LO), .SW_CNT(SW_CNT),
      .EXT_LO(EXT_LO), .EXT_CNT(EXT_CNT), .LVL_W(LVL_W)
   ) u_sel (
      .sw_req  (sw_req),
      .ext_req (ext_req),
      .lvl     (lvl_c),
      .summary (sum_c)
   );

   assign do_eval = eval_strobe && armed_q;
   assign fire    = do_eval && (lvl_c != '0) && (lvl_c > cur_lvl);

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q  <= 1'b1;
         trap_req <= 1'b0;
         ast_err  <= 1'b0;
         isr_sum  <= '0;
         intid    <= '0;
      end else begin
         trap_req <= fire;
         ast_err  <= do_eval && (ast_req != '0);
         if (handler_ret)  armed_q <= 1'b1;
         else if (do_eval) armed_q <= 1'b0;
         if (fire) begin
            isr_sum <= sum_c;
            intid   <= lvl_c;
         end
      end
   end

   AST_TRAP_NONZERO: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> (intid != '0));                                        // R5
   AST_TRAP_ABOVE_CUR: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> (intid > $past(cur_lvl)));                             // R5
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
      !trap_req |-> ($stable(isr_sum) && $stable(intid)));                // R6
   AST_NO_REEVAL: assert property (@(posedge clk) disable iff (rst)
      (trap_req && !$past(handler_ret)) |=> !trap_req);                   // R7
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
      ast_err |-> ($past(ast_req) != '0));                                // R8
endmodule

// File: tb/irq_level_arbiter_tb.sv
`timescale 1ns/1ps
module irq_level_arbiter_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        eval_strobe = 1'b0;
   logic        handler_ret = 1'b0;
   logic [31:0] sw_req = '0;
   logic [31:0] ext_req = '0;
   logic [3:0]  ast_req = '0;
   logic [4:0]  cur_lvl = '0;
   logic        trap_req;
   logic [31:0] isr_sum;
   logic [4:0]  intid;
   logic        ast_err;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] exp_sum = '0;
   logic [4:0]  exp_id  = '0;

   always #2 clk = ~clk;

   irq_level_arbiter dut_i (
      .clk(clk), .rst(rst), .eval_strobe(eval_strobe), .handler_ret(handler_ret),
      .sw_req(sw_req), .ext_req(ext_req), .ast_req(ast_req), .cur_lvl(cur_lvl),
      .trap_req(trap_req), .isr_sum(isr_sum), .intid(intid), .ast_err(ast_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // arithmetic reference: sw positions 4..18 -> p-3, ext positions 20..30 -> p
   task automatic model(input logic [31:0] sw, input logic [31:0] ext,
                        output logic [4:0] lvl, output logic [31:0] sum);
      lvl = '0;
      for (int p = 4; p <= 18; p++) if (sw[p]) lvl = 5'(p - 3);
      for (int p = 20; p <= 30; p++) if (ext[p]) lvl = 5'(p);
      sum = (sw & 32'h0007_FFF0) | (ext & 32'h7FF0_0000);
   endtask

   task automatic rearm();
      @(negedge clk); handler_ret = 1'b1;
      @(negedge clk); handler_ret = 1'b0;
   endtask

   // one armed evaluation; checks trap, status and the error pulse
   task automatic eval_once(input string tag, input logic [31:0] sw,
                            input logic [31:0] ext, input logic [4:0] cur,
                            input logic [3:0] ast);
      logic [4:0]  lvl;
      logic [31:0] sum;
      logic        fire;
      model(sw, ext, lvl, sum);
      fire = (lvl != 0) && (lvl > cur);
      @(negedge clk);
      sw_req = sw; ext_req = ext; cur_lvl = cur; ast_req = ast; eval_strobe = 1'b1;
      @(negedge clk);
      eval_strobe = 1'b0; ast_req = '0;
      if (fire) begin exp_sum = sum; exp_id = lvl; end
      check({tag, " R5 trap"}, 32'(trap_req), 32'(fire));
      check({tag, " R4 sum"}, isr_sum, exp_sum);
      check({tag, " R2/R3 intid"}, 32'(intid), 32'(exp_id));
      check({tag, " R8 err"}, 32'(ast_err), 32'(ast != 0));
      @(negedge clk);
      check({tag, " R6 pulse"}, 32'(trap_req), 32'd0);
      check({tag, " R6 hold"}, isr_sum, exp_sum);
      rearm();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 trap", 32'(trap_req), 0);
      check("R1 err", 32'(ast_err), 0);
      check("R1 sum", isr_sum, 0);
      check("R1 intid", 32'(intid), 0);

      // R2: every single software bit against every priority level
      for (int p = 4; p <= 18; p++)
         for (int c = 0; c < 32; c++)
            eval_once("R2 sw", 32'd1 << p, 0, 5'(c), 0);
      // R3: every single external bit against every priority level
      for (int p = 20; p <= 30; p++)
         for (int c = 0; c < 32; c++)
            eval_once("R3 ext", 0, 32'd1 << p, 5'(c), 0);
      // R3: external overrides software for every pair
      for (int s = 4; s <= 18; s++)
         for (int e = 20; e <= 30; e++)
            eval_once("R3 pair", 32'd1 << s, 32'd1 << e, 5'd0, 0);
      // R4: out-of-range bits ignored
      eval_once("R4 oor", 32'h8008_000F, 32'h800F_FFFF, 5'd0, 0);
      eval_once("R4 mix", 32'h8008_002F, 32'h804F_FFFF, 5'd0, 0);
      // R5: zero level never traps even with cur 0
      eval_once("R5 none", 0, 0, 5'd0, 0);
      // pseudo-random words
      lfsr = 32'hACE1_2468;
      for (int k = 0; k < 300; k++) begin
         logic [31:0] a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         eval_once("R2 rnd", a, (k % 3 == 0) ? lfsr : 32'h0, 5'(k), 0);
      end
      // R8: error with and without a trap
      eval_once("R8 err", 0, 0, 5'd0, 4'h3);
      eval_once("R8 err+trap", 32'h0004_0000, 0, 5'd0, 4'h8);

      // R7: second strobe without return is ignored
      eval_once("R7 setup", 32'h0000_0010, 0, 5'd0, 0);  // intid 1
      @(negedge clk);
      sw_req = 32'h0004_0000; cur_lvl = 0; eval_strobe = 1'b1;
      @(negedge clk);
      eval_strobe = 1'b0;                       // consumes armed state
      check("R7 first", 32'(trap_req), 1);
      check("R7 first id", 32'(intid), 15);
      @(negedge clk);
      ext_req = 32'h4000_0000; ast_req = 4'h1; eval_strobe = 1'b1;
      @(negedge clk);
      eval_strobe = 1'b0; ast_req = 0;
      check("R7 ignored trap", 32'(trap_req), 0);
      check("R7 ignored err", 32'(ast_err), 0);
      check("R7 ignored id", 32'(intid), 15);
      // strobe with return in the same cycle keeps it armed
      rearm();
      @(negedge clk);
      eval_strobe = 1'b1; handler_ret = 1'b1;
      @(negedge clk);
      handler_ret = 1'b0;                       // strobe stays high: second eval
      check("R7 same-cycle trap", 32'(trap_req), 1);
      check("R7 same-cycle id", 32'(intid), 30);
      @(negedge clk);
      eval_strobe = 1'b0;
      check("R7 re-eval trap", 32'(trap_req), 1);
      @(negedge clk);
      check("R7 disarmed", 32'(trap_req), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule